// File: doc/BRIEF.md
# Memory Access Watchpoint Unit

This block observes every memory access granted by a multi-client memory arbiter. It compares each access against four independent watchpoints. A watchpoint is defined by an inclusive address window, a mask of the access kinds it cares about (read, write) and a mask of the requesting clients it cares about. When an access satisfies all three conditions, that watchpoint records a diagnostic snapshot of the offending access and raises a status bit for an interrupt.

The snapshot keeps the address, the access kind, the index of the client that caused the first hit and the transfer size of that first hit. It is held until software releases it. While it is held, further hits on the same watchpoint only add their client to a set of accumulated client bits. Interrupt control has two levels:
- a per-watchpoint acknowledge releases the snapshot;
- a global mask gates each watchpoint's status onto the interrupt line;
- a global acknowledge clears each watchpoint's status bit.

The access port is a pure observation stream, qualified by `acc_valid` and never stalled. There is no ready signal, and the unit accepts one access on every cycle without applying back-pressure. Configuration, masks and acknowledges are plain level or pulse inputs sampled on the rising clock edge.

Top module: `mem_watch_unit`

## Requirements
- R1: After reset, every snapshot is empty: the valid bit, client bits, address, kind, first client and size are all zero. All status bits are clear and `irq` is low.
- R2: The address window is inclusive at both ends. An access matches a watchpoint only when first ≤ `acc_addr` ≤ last, compared as unsigned numbers.
- R3: Operation-mask bit 0 enables matching of reads (`acc_write`=0), and bit 1 enables matching of writes (`acc_write`=1).
- R4: Client-mask bit k enables matching of client index k. A client index equal to or above NUM_CLIENTS never matches.
- R5: A hit on an empty watchpoint loads its snapshot on the clock edge that samples the access. The snapshot becomes visible one cycle later: valid=1, client bits equal to the one-hot of the client index, and the address, kind, client index and size of that access.
- R6: While a snapshot is held, later hits leave the address, kind, first client and size unchanged. They only OR their client's one-hot bit into the client bits.
- R7: A per-watchpoint acknowledge pulse empties that snapshot, setting all fields to zero. If a hit on the same watchpoint arrives in the same cycle, the snapshot is instead reloaded fresh from that hit.
- R8: A hit sets the watchpoint's raw status bit. The bit stays set until a global acknowledge pulse for that bit arrives. If a hit and a global acknowledge coincide, the hit wins.
- R9: `int_status` equals the raw status ANDed with `irq_mask`, without delay, and `irq` is the OR of `int_status`.
- R10: Watchpoints are independent. A single access may hit several of them in the same cycle, and an acknowledge on one watchpoint never affects another.
- R11: With `acc_valid` low, no watchpoint changes state because of the access inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Observed access present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_client | input | CID_W | Index of requesting client |
| acc_size | input | SIZE_W | Transfer size code |
| cfg_first | input | NUM_WP*ADDR_W | Lower window bound per watchpoint (slice i) |
| cfg_last | input | NUM_WP*ADDR_W | Upper window bound per watchpoint |
| cfg_op | input | NUM_WP*2 | Operation mask per watchpoint, bit0 read, bit1 write |
| cfg_clients | input | NUM_WP*NUM_CLIENTS | Client mask per watchpoint |
| wp_ack | input | NUM_WP | Per-watchpoint snapshot release pulse |
| irq_mask | input | NUM_WP | Global interrupt enable per watchpoint |
| irq_ack | input | NUM_WP | Global status clear pulse per watchpoint |
| cap_valid | output | NUM_WP | Snapshot held |
| cap_clients | output | NUM_WP*NUM_CLIENTS | Accumulated client bits |
| cap_addr | output | NUM_WP*ADDR_W | Address of first hit |
| cap_write | output | NUM_WP | Kind of first hit |
| cap_first | output | NUM_WP*CID_W | Client index of first hit |
| cap_size | output | NUM_WP*SIZE_W | Size of first hit |
| int_status | output | NUM_WP | Masked status |
| irq | output | 1 | OR of masked status |

## Verification
The bench builds the unit with its default parameters: four watchpoints, 14 clients, 32-bit addresses and 3-bit sizes. Because 14 clients need a 4-bit index, indices 14 and 15 can be driven and exercise the out-of-range client case. With full 32-bit addresses, a window that ends at the top of the address space tests the inclusive upper bound without wrap-around. Four watchpoints with overlapping windows allow one access to hit two of them at once, while acknowledges land on only one.

// File: rtl/mwu_pkg.sv
`timescale 1ns/1ps
package mwu_pkg;
  // Operation-mask layout shared by match logic and bench-visible config.
  localparam int OP_W  = 2;
  localparam int OP_RD = 0;
  localparam int OP_WR = 1;

  typedef enum logic {
    KIND_READ  = 1'b0,
    KIND_WRITE = 1'b1
  } acc_kind_e;

  function automatic int unsigned op_bit(input acc_kind_e kind);
    return (kind == KIND_WRITE) ? OP_WR : OP_RD;
  endfunction
endpackage

// File: rtl/mwu_match.sv
`timescale 1ns/1ps
module mwu_match
  import mwu_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_CLIENTS = 14
) (
  input  logic                   acc_valid,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic                   acc_write,
  input  logic [NUM_CLIENTS-1:0] client_1hot,
  input  logic [ADDR_W-1:0]      win_lo,
  input  logic [ADDR_W-1:0]      win_hi,
  input  logic [OP_W-1:0]        op_en,
  input  logic [NUM_CLIENTS-1:0] client_en,
  output logic                   hit
);
  logic in_range;
  logic op_ok;
  logic client_ok;
  acc_kind_e kind;

  assign kind      = acc_kind_e'(acc_write);
  assign in_range  = (acc_addr >= win_lo) && (acc_addr <= win_hi);
  assign op_ok     = op_en[op_bit(kind)];
  assign client_ok = |(client_1hot & client_en);
  assign hit       = acc_valid && in_range && op_ok && client_ok;
endmodule

// File: rtl/mwu_capture.sv
`timescale 1ns/1ps
module mwu_capture #(
  parameter int ADDR_W      = 32,
  parameter int NUM_CLIENTS = 14,
  parameter int CID_W       = 4,
  parameter int SIZE_W      = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hit,
  input  logic                   ack,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic                   acc_write,
  input  logic [CID_W-1:0]       acc_client,
  input  logic [SIZE_W-1:0]      acc_size,
  input  logic [NUM_CLIENTS-1:0] client_1hot,
  output logic                   snap_valid,
  output logic [NUM_CLIENTS-1:0] snap_clients,
  output logic [ADDR_W-1:0]      snap_addr,
  output logic                   snap_write,
  output logic [CID_W-1:0]       snap_first,
  output logic [SIZE_W-1:0]      snap_size
);
  logic fresh;

  // A hit opens a new snapshot when none is held or when the held one is
  // being released in this very cycle.
  assign fresh = hit && (!snap_valid || ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_valid   <= 1'b0;
      snap_clients <= '0;
      snap_addr    <= '0;
      snap_write   <= 1'b0;
      snap_first   <= '0;
      snap_size    <= '0;
    end else if (fresh) begin
      snap_valid   <= 1'b1;
      snap_clients <= client_1hot;
      snap_addr    <= acc_addr;
      snap_write   <= acc_write;
      snap_first   <= acc_client;
      snap_size    <= acc_size;
    end else if (hit) begin
      snap_clients <= snap_clients | client_1hot;
    end else if (ack) begin
      snap_valid   <= 1'b0;
      snap_clients <= '0;
      snap_addr    <= '0;
      snap_write   <= 1'b0;
      snap_first   <= '0;
      snap_size    <= '0;
    end
  end
endmodule

// File: rtl/mwu_irq.sv
`timescale 1ns/1ps
module mwu_irq #(
  parameter int NUM_WP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_WP-1:0] hit,
  input  logic [NUM_WP-1:0] gack,
  input  logic [NUM_WP-1:0] mask,
  output logic [NUM_WP-1:0] raw,
  output logic [NUM_WP-1:0] masked,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= '0;
    else        raw <= (raw & ~gack) | hit;
  end

  assign masked = raw & mask;
  assign irq    = |masked;
endmodule

// File: rtl/mem_watch_unit.sv
`timescale 1ns/1ps
module mem_watch_unit
  import mwu_pkg::*;
#(
  parameter  int NUM_WP      = 4,
  parameter  int NUM_CLIENTS = 14,
  parameter  int ADDR_W      = 32,
  parameter  int SIZE_W      = 3,
  localparam int CID_W       = $clog2(NUM_CLIENTS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          acc_valid,
  input  logic [ADDR_W-1:0]             acc_addr,
  input  logic                          acc_write,
  input  logic [CID_W-1:0]              acc_client,
  input  logic [SIZE_W-1:0]             acc_size,
  input  logic [NUM_WP*ADDR_W-1:0]      cfg_first,
  input  logic [NUM_WP*ADDR_W-1:0]      cfg_last,
  input  logic [NUM_WP*OP_W-1:0]        cfg_op,
  input  logic [NUM_WP*NUM_CLIENTS-1:0] cfg_clients,
  input  logic [NUM_WP-1:0]             wp_ack,
  input  logic [NUM_WP-1:0]             irq_mask,
  input  logic [NUM_WP-1:0]             irq_ack,
  output logic [NUM_WP-1:0]             cap_valid,
  output logic [NUM_WP*NUM_CLIENTS-1:0] cap_clients,
  output logic [NUM_WP*ADDR_W-1:0]      cap_addr,
  output logic [NUM_WP-1:0]             cap_write,
  output logic [NUM_WP*CID_W-1:0]       cap_first,
  output logic [NUM_WP*SIZE_W-1:0]      cap_size,
  output logic [NUM_WP-1:0]             int_status,
  output logic                          irq
);
  logic [NUM_CLIENTS-1:0] client_1hot;
  logic [NUM_WP-1:0]      hit_vec;
  logic [NUM_WP-1:0]      raw_stat;

  // Client index decoded once and shared by all watchpoints; indices at or
  // above NUM_CLIENTS decode to all zeros and so never match.
  for (genvar c = 0; c < NUM_CLIENTS; c++) begin : g_dec
    assign client_1hot[c] = (acc_client == CID_W'(c));
  end

  for (genvar w = 0; w < NUM_WP; w++) begin : g_wp
    mwu_match #(
      .ADDR_W      (ADDR_W),
      .NUM_CLIENTS (NUM_CLIENTS)
    ) u_match (
      .acc_valid   (acc_valid),
      .acc_addr    (acc_addr),
      .acc_write   (acc_write),
      .client_1hot (client_1hot),
      .win_lo      (cfg_first[w*ADDR_W +: ADDR_W]),
      .win_hi      (cfg_last[w*ADDR_W +: ADDR_W]),
      .op_en       (cfg_op[w*OP_W +: OP_W]),
      .client_en   (cfg_clients[w*NUM_CLIENTS +: NUM_CLIENTS]),
      .hit         (hit_vec[w])
    );

    mwu_capture #(
      .ADDR_W      (ADDR_W),
      .NUM_CLIENTS (NUM_CLIENTS),
      .CID_W       (CID_W),
      .SIZE_W      (SIZE_W)
    ) u_cap (
      .clk          (clk),
      .rst_n        (rst_n),
      .hit          (hit_vec[w]),
      .ack          (wp_ack[w]),
      .acc_addr     (acc_addr),
      .acc_write    (acc_write),
      .acc_client   (acc_client),
      .acc_size     (acc_size),
      .client_1hot  (client_1hot),
      .snap_valid   (cap_valid[w]),
      .snap_clients (cap_clients[w*NUM_CLIENTS +: NUM_CLIENTS]),
      .snap_addr    (cap_addr[w*ADDR_W +: ADDR_W]),
      .snap_write   (cap_write[w]),
      .snap_first   (cap_first[w*CID_W +: CID_W]),
      .snap_size    (cap_size[w*SIZE_W +: SIZE_W])
    );
  end

  mwu_irq #(
    .NUM_WP (NUM_WP)
  ) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit_vec),
    .gack   (irq_ack),
    .mask   (irq_mask),
    .raw    (raw_stat),
    .masked (int_status),
    .irq    (irq)
  );
endmodule

// File: rtl/mem_watch_unit_chk.sv
`timescale 1ns/1ps
module mem_watch_unit_chk #(
  parameter int NUM_WP      = 4,
  parameter int NUM_CLIENTS = 14,
  parameter int ADDR_W      = 32,
  parameter int CID_W       = 4,
  parameter int SIZE_W      = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          acc_valid,
  input logic [NUM_WP-1:0]             wp_ack,
  input logic [NUM_WP-1:0]             irq_ack,
  input logic [NUM_WP-1:0]             hit_vec,
  input logic [NUM_WP-1:0]             raw_stat,
  input logic [NUM_WP-1:0]             cap_valid,
  input logic [NUM_WP*NUM_CLIENTS-1:0] cap_clients,
  input logic [NUM_WP*ADDR_W-1:0]      cap_addr,
  input logic [NUM_WP*CID_W-1:0]       cap_first,
  input logic [NUM_WP*SIZE_W-1:0]      cap_size
);
  for (genvar w = 0; w < NUM_WP; w++) begin : g_chk
    // R6: a held snapshot keeps its first-hit fields
    a_r6_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid[w] && !wp_ack[w] |=> cap_valid[w]
        && $stable(cap_addr[w*ADDR_W +: ADDR_W])
        && $stable(cap_first[w*CID_W +: CID_W])
        && $stable(cap_size[w*SIZE_W +: SIZE_W]));

    // R6: client bits only grow while held
    a_r6_clients_grow: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid[w] && !wp_ack[w] |=>
        ((cap_clients[w*NUM_CLIENTS +: NUM_CLIENTS]
          & $past(cap_clients[w*NUM_CLIENTS +: NUM_CLIENTS]))
         == $past(cap_clients[w*NUM_CLIENTS +: NUM_CLIENTS])));

    // R7: acknowledge without a hit empties the snapshot
    a_r7_ack_empties: assert property (@(posedge clk) disable iff (!rst_n)
      wp_ack[w] && !hit_vec[w] |=> !cap_valid[w]
        && (cap_clients[w*NUM_CLIENTS +: NUM_CLIENTS] == '0));

    // R5, R8: a hit leaves both a snapshot and a raised status
    a_r8_hit_raises: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vec[w] |=> raw_stat[w] && cap_valid[w]);

    // R8: status is sticky until its global acknowledge
    a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      raw_stat[w] && !irq_ack[w] |=> raw_stat[w]);

    // R11: no match without a valid access
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !hit_vec[w]);
  end
endmodule

bind mem_watch_unit mem_watch_unit_chk #(
  .NUM_WP      (NUM_WP),
  .NUM_CLIENTS (NUM_CLIENTS),
  .ADDR_W      (ADDR_W),
  .CID_W       (CID_W),
  .SIZE_W      (SIZE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .wp_ack      (wp_ack),
  .irq_ack     (irq_ack),
  .hit_vec     (hit_vec),
  .raw_stat    (raw_stat),
  .cap_valid   (cap_valid),
  .cap_clients (cap_clients),
  .cap_addr    (cap_addr),
  .cap_first   (cap_first),
  .cap_size    (cap_size)
);

// File: tb/mem_watch_unit_tb.sv
`timescale 1ns/1ps
module mem_watch_unit_tb;
  localparam int NW = 4;
  localparam int NC = 14;
  localparam int AW = 32;
  localparam int CW = 4;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic          acc_write = 1'b0;
  logic [CW-1:0] acc_client = '0;
  logic [SW-1:0] acc_size = '0;
  logic [NW-1:0] wp_ack = '0;
  logic [NW-1:0] irq_mask = '0;
  logic [NW-1:0] irq_ack = '0;

  logic [AW-1:0] b_first [NW];
  logic [AW-1:0] b_last  [NW];
  logic [1:0]    b_op    [NW];
  logic [NC-1:0] b_cm    [NW];

  logic [NW*AW-1:0] cfg_first, cfg_last;
  logic [NW*2-1:0]  cfg_op;
  logic [NW*NC-1:0] cfg_clients;

  always_comb begin
    for (int i = 0; i < NW; i++) begin
      cfg_first[i*AW +: AW]   = b_first[i];
      cfg_last[i*AW +: AW]    = b_last[i];
      cfg_op[i*2 +: 2]        = b_op[i];
      cfg_clients[i*NC +: NC] = b_cm[i];
    end
  end

  logic [NW-1:0]    cap_valid, cap_write, int_status;
  logic [NW*NC-1:0] cap_clients;
  logic [NW*AW-1:0] cap_addr;
  logic [NW*CW-1:0] cap_first;
  logic [NW*SW-1:0] cap_size;
  logic             irq;

  mem_watch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_client(acc_client), .acc_size(acc_size),
    .cfg_first(cfg_first), .cfg_last(cfg_last), .cfg_op(cfg_op),
    .cfg_clients(cfg_clients), .wp_ack(wp_ack), .irq_mask(irq_mask),
    .irq_ack(irq_ack), .cap_valid(cap_valid), .cap_clients(cap_clients),
    .cap_addr(cap_addr), .cap_write(cap_write), .cap_first(cap_first),
    .cap_size(cap_size), .int_status(int_status), .irq(irq)
  );

  // Behavioural reference state
  logic          m_v   [NW];
  logic [NC-1:0] m_cl  [NW];
  logic [AW-1:0] m_a   [NW];
  logic          m_w   [NW];
  logic [CW-1:0] m_f   [NW];
  logic [SW-1:0] m_s   [NW];
  logic          m_raw [NW];

  int    n_vec = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  string phase = "R1";

  function automatic bit ref_hit(int i);
    if (!acc_valid) return 0;                                    // R11
    if (acc_addr < b_first[i] || acc_addr > b_last[i]) return 0; // R2
    if (!b_op[i][acc_write ? 1 : 0]) return 0;                   // R3
    if (int'(acc_client) >= NC) return 0;                        // R4
    return b_cm[i][acc_client];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) begin
        m_v[i] = 0; m_cl[i] = '0; m_a[i] = '0; m_w[i] = 0;
        m_f[i] = '0; m_s[i] = '0; m_raw[i] = 0;
      end
    end else begin
      for (int i = 0; i < NW; i++) begin
        bit h;
        h = ref_hit(i);
        if (h && (!m_v[i] || wp_ack[i])) begin
          m_v[i] = 1; m_cl[i] = NC'(1) << acc_client; m_a[i] = acc_addr;
          m_w[i] = acc_write; m_f[i] = acc_client; m_s[i] = acc_size;
        end else if (h) begin
          m_cl[i] = m_cl[i] | (NC'(1) << acc_client);
        end else if (wp_ack[i]) begin
          m_v[i] = 0; m_cl[i] = '0; m_a[i] = '0; m_w[i] = 0;
          m_f[i] = '0; m_s[i] = '0;
        end
        if (h) m_raw[i] = 1;
        else if (irq_ack[i]) m_raw[i] = 0;
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // Compare every cycle at the falling edge, away from the active edge.
  always @(negedge clk) begin
    logic [NW-1:0] exp_st;
    for (int i = 0; i < NW; i++) begin
      chk({phase, " snapshot valid (R5/R7)"}, cap_valid[i], m_v[i]);
      chk({phase, " client bits (R6)"}, cap_clients[i*NC +: NC], m_cl[i]);
      chk({phase, " address (R5)"}, cap_addr[i*AW +: AW], m_a[i]);
      chk({phase, " kind (R5)"}, cap_write[i], m_w[i]);
      chk({phase, " first client (R5)"}, cap_first[i*CW +: CW], m_f[i]);
      chk({phase, " size (R5)"}, cap_size[i*SW +: SW], m_s[i]);
      exp_st[i] = m_raw[i] & irq_mask[i];
    end
    chk({phase, " masked status (R9/R8)"}, int_status, exp_st);
    chk({phase, " irq (R9)"}, irq, |exp_st);
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic drive(input logic v, input logic [AW-1:0] a, input logic w,
                       input logic [CW-1:0] c, input logic [SW-1:0] s,
                       input logic [NW-1:0] wa, input logic [NW-1:0] ga);
    @(posedge clk); #1;
    acc_valid = v; acc_addr = a; acc_write = w; acc_client = c; acc_size = s;
    wp_ack = wa; irq_ack = ga;
  endtask

  task automatic idle();
    drive(0, '0, 0, '0, '0, '0, '0);
  endtask

  initial begin
    b_first[0] = 32'h0000_1000; b_last[0] = 32'h0000_10FF; b_op[0] = 2'b11; b_cm[0] = '1;
    b_first[1] = 32'h0000_1080; b_last[1] = 32'h0000_2000; b_op[1] = 2'b10; b_cm[1] = 14'h0028;
    b_first[2] = 32'hFFFF_FF00; b_last[2] = 32'hFFFF_FFFF; b_op[2] = 2'b01; b_cm[2] = '1;
    b_first[3] = 32'h0;         b_last[3] = 32'h0;         b_op[3] = 2'b11; b_cm[3] = 14'h2000;
    irq_mask = 4'b1111;

    phase = "R1";
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle();

    phase = "R11";
    drive(0, 32'h1000, 0, 4'd0, 3'd1, '0, '0);
    idle();

    phase = "R2";
    drive(1, 32'h0FFF, 0, 4'd0, 3'd1, '0, '0);  // below window
    drive(1, 32'h1100, 0, 4'd0, 3'd1, '0, '0);  // above wp0, read not allowed on wp1
    idle();
    @(negedge clk);
    chk("R2 no hit outside window", cap_valid, 4'b0000);
    drive(1, 32'h1000, 0, 4'd0, 3'd2, '0, '0);  // lower bound hit
    idle();

    phase = "R6";
    drive(1, 32'h10FF, 0, 4'd2, 3'd5, '0, '0);  // upper bound, another client
    idle();

    phase = "R7";
    drive(0, '0, 0, '0, '0, 4'b0001, '0);
    idle();

    phase = "R8";
    drive(0, '0, 0, '0, '0, '0, 4'b0001);
    idle();

    phase = "R3";
    drive(1, 32'h1500, 0, 4'd3, 3'd1, '0, '0);  // read, wp1 writes only
    drive(1, 32'h1500, 1, 4'd3, 3'd3, '0, '0);  // write hits wp1
    drive(1, 32'hFFFF_FFFF, 1, 4'd1, 3'd0, '0, '0); // write, wp2 reads only
    drive(1, 32'hFFFF_FFFF, 0, 4'd1, 3'd7, '0, '0); // read hits wp2
    idle();

    phase = "R4";
    drive(1, 32'h1600, 1, 4'd4, 3'd1, '0, '0);  // client not in wp1 mask
    drive(1, 32'h0, 0, 4'd14, 3'd1, '0, '0);    // out-of-range client
    drive(1, 32'h0, 0, 4'd15, 3'd1, '0, '0);
    idle();
    @(negedge clk);
    chk("R4 out-of-range client ignored", cap_valid[3], 1'b0);
    drive(1, 32'h0, 1, 4'd13, 3'd4, '0, '0);
    idle();

    phase = "R10";
    drive(1, 32'h1090, 1, 4'd5, 3'd2, '0, '0);  // hits wp0 and wp1
    drive(0, '0, 0, '0, '0, 4'b0010, 4'b0010);  // only wp1 released
    idle();

    phase = "R9";
    for (int m = 0; m < 16; m++) begin
      @(posedge clk); #1 irq_mask = 4'(m);
    end
    irq_mask = 4'b1111;

    phase = "R7";
    drive(1, 32'h1010, 1, 4'd7, 3'd6, 4'b0001, '0);  // ack and hit together
    idle();

    phase = "R8";
    drive(1, 32'h1020, 0, 4'd8, 3'd1, '0, 4'b0001);  // hit wins over global ack
    idle();

    phase = "RND";
    for (int k = 0; k < 600; k++) begin
      logic [AW-1:0] a;
      case ($urandom_range(0, 5))
        0: a = 32'h1000 + 32'($urandom_range(0, 255));
        1: a = 32'h1080 + 32'($urandom_range(0, 4000));
        2: a = 32'hFFFF_FF00 + 32'($urandom_range(0, 255));
        3: a = 32'h0;
        4: a = 32'h0FFF;
        default: a = $urandom;
      endcase
      if ($urandom_range(0, 7) == 0) irq_mask = 4'($urandom);
      drive(1'($urandom), a, 1'($urandom), 4'($urandom_range(0, 15)),
            3'($urandom), ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'b0,
            ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'b0);
    end
    idle();
    idle();
    @(negedge clk);
    #1 finish_run();
  end
endmodule